// File: doc/BRIEF.md
# Flash Bank Decoder and Access Guard

This block sits on the path from a CPU bus to a 128 KB on-chip flash array that is 32 bits wide. For each request it resolves the 24-bit byte address into one of four erase banks of unequal size (8 KB, 24 KB, 48 KB, 48 KB). It also drives a read strobe and a word index into the array, and returns a response one cycle later. The response carries the bank number, the word index, region flags and the full 32-bit word.

The two small low banks can sit either at the bottom of the address space or 64 KB higher. The placement is sampled once, right after reset, and then held. The two large banks never move. Addresses that decode to no bank are reported as external, so off-chip memory can answer them. A 1 KB on-chip RAM window is also recognised, but only so the guard can apply its rules to it.

Two conditions refuse an access. While a program or erase operation is busy, every fetch or read aimed at flash is refused. While read protection is on, data reads of flash or of the RAM window are refused, but instruction fetches from flash still go through. A refused access raises a one-cycle error with zero data and never strobes the array.

Top module: `flash_bank_guard`

## Requirements
- R1: With `remap_sel_i`=0 latched, bytes 0x000000–0x001FFF decode to bank 0 and 0x002000–0x007FFF to bank 1, with `rsp_hit_o`=1 and `rsp_word_o` = address >> 2; bytes 0x010000–0x017FFF are external.
- R2: With `remap_sel_i`=1 latched, bytes 0x010000–0x011FFF decode to bank 0 and 0x012000–0x017FFF to bank 1, with `rsp_word_o` = (address − 0x010000) >> 2; bytes 0x000000–0x007FFF are external.
- R3: Under either placement, bytes 0x018000–0x023FFF decode to bank 2 and 0x024000–0x02FFFF to bank 3, with `rsp_word_o` = (address − 0x010000) >> 2.
- R4: Each response raises exactly one of `rsp_hit_o`, `rsp_ram_o` (bytes RAM_BASE to RAM_BASE+RAM_BYTES−1, default 0x00FA00–0x00FDFF), `rsp_ext_o`. When `rsp_hit_o`=0, bank and word read 0.
- R5: The placement is taken from `remap_sel_i` on the first clock edge after reset is released. Later changes of that input have no effect until the next reset.
- R6: When `flash_busy_i`=1, any fetch or read that hits flash gives `rsp_err_o`=1 and `rsp_data_o`=0, and `arr_en_o` stays 0. Bank and word are still reported.
- R7: When `protect_i`=1, a data read (`req_fetch_i`=0) that hits flash or the RAM window gives `rsp_err_o`=1 and zero data. A fetch (`req_fetch_i`=1) from flash returns the array word with no error.
- R8: Every response appears exactly one cycle after its request. A cycle with no request gives `rsp_valid_o`=0 and `rsp_err_o`=0 in the next cycle.
- R9: An accepted flash access raises `arr_en_o` in the request cycle with `arr_addr_o` equal to the decoded word index. In the response cycle, `rsp_data_o` carries all 32 bits of `arr_rdata_i`.
- R10: During and right after reset, `rsp_valid_o`, `rsp_err_o` and `rsp_data_o` are 0.
- R11: Busy has no effect on RAM-window or external accesses. Protection has no effect on fetches or on external reads. Accepted non-flash accesses give zero data and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| remap_sel_i | input | 1 | Low-bank placement: 0 at the bottom, 1 at 0x010000 |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 24 | Byte address |
| req_fetch_i | input | 1 | 1 = instruction fetch, 0 = data read |
| flash_busy_i | input | 1 | Program or erase operation in progress |
| protect_i | input | 1 | Read protection enabled |
| arr_en_o | output | 1 | Array read strobe |
| arr_addr_o | output | 15 | Array word index |
| arr_rdata_i | input | 32 | Array word, valid the cycle after the strobe |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Address is in flash |
| rsp_ram_o | output | 1 | Address is in the on-chip RAM window |
| rsp_ext_o | output | 1 | Address belongs to external memory |
| rsp_bank_o | output | 2 | Erase bank index |
| rsp_word_o | output | 15 | Word index within the array |
| rsp_err_o | output | 1 | Access refused (one-cycle error) |
| rsp_data_o | output | 32 | Read data, zero unless an accepted flash access |

## Verification
Only the array strobe and the word index are combinational. They are checked a short delay after the inputs change, still inside the request cycle. All response fields, including the error pulse, are registered once and appear in the next cycle. Read data comes from the array's own one-cycle latency and lines up with them. The bench therefore applies each request on a falling edge, waits for one rising edge, and reads the response at the following falling edge. After that it drops the request, so the next cycle can also be checked for silence.

// File: rtl/flsh_pkg.sv
package flsh_pkg;

    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 32;
    localparam int NUM_BANKS  = 4;
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int FLASH_BYTES = 128 * 1024;
    localparam int WORD_W     = $clog2(FLASH_BYTES / 4);
    localparam logic [ADDR_W-1:0] HIGH_BASE = 24'h010000;
    localparam int MOVABLE_BANKS = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [1:0] {
        REG_EXT   = 2'd0,
        REG_FLASH = 2'd1,
        REG_RAM   = 2'd2
    } region_e;

    typedef struct packed {
        region_e region;
        bank_t   bank;
        word_t   word;
    } decode_t;

    typedef struct packed {
        logic  valid;
        logic  hit;
        logic  ram;
        logic  ext;
        bank_t bank;
        word_t word;
        logic  err;
        logic  pass_data;
    } resp_t;

    function automatic addr_t bank_bytes(input int b);
        case (b)
            0:       return addr_t'(8 * 1024);
            1:       return addr_t'(24 * 1024);
            default: return addr_t'(48 * 1024);
        endcase
    endfunction

    function automatic addr_t bank_phys(input int b);
        addr_t acc;
        acc = '0;
        for (int i = 0; i < b; i++) acc = acc + bank_bytes(i);
        return acc;
    endfunction

    function automatic addr_t bank_lo(input int b, input logic high);
        if (b >= MOVABLE_BANKS || high) return bank_phys(b) + HIGH_BASE;
        return bank_phys(b);
    endfunction

endpackage

// File: rtl/flsh_remap_latch.sv
module flsh_remap_latch (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    output logic high_o,
    output logic high_q_o,
    output logic done_o
);
    logic high_q;
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_q <= 1'b0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            high_q <= sel_i;
            done_q <= 1'b1;
        end
    end

    assign high_o   = done_q ? high_q : sel_i;
    assign high_q_o = high_q;
    assign done_o   = done_q;
endmodule

// File: rtl/flsh_bank_decode.sv
module flsh_bank_decode
    import flsh_pkg::*;
#(
    parameter logic [23:0] RAM_BASE  = 24'h00FA00,
    parameter int          RAM_BYTES = 1024
) (
    input  addr_t   addr_i,
    input  logic    high_i,
    output decode_t dec_o
);
    localparam addr_t RAM_END = RAM_BASE + addr_t'(RAM_BYTES);

    logic [NUM_BANKS-1:0] bank_hit;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam addr_t LO_LOW  = bank_lo(b, 1'b0);
        localparam addr_t LO_HIGH = bank_lo(b, 1'b1);
        localparam addr_t SIZE    = bank_bytes(b);
        addr_t lo;
        assign lo          = high_i ? LO_HIGH : LO_LOW;
        assign bank_hit[b] = (addr_i >= lo) && (addr_i < lo + SIZE);
    end

    addr_t phys;
    logic  in_ram;

    assign in_ram = (addr_i >= RAM_BASE) && (addr_i < RAM_END);

    always_comb begin
        dec_o = '{region: REG_EXT, bank: '0, word: '0};
        phys  = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (bank_hit[b]) begin
                dec_o.region = REG_FLASH;
                dec_o.bank   = bank_t'(b);
                if (b >= MOVABLE_BANKS || high_i) phys = addr_i - HIGH_BASE;
                else                               phys = addr_i;
            end
        end
        if (dec_o.region == REG_FLASH) begin
            dec_o.word = phys[WORD_W+1:2];
        end else if (in_ram) begin
            dec_o.region = REG_RAM;
        end
    end
endmodule

// File: rtl/flsh_access_policy.sv
module flsh_access_policy
    import flsh_pkg::*;
(
    input  logic    valid_i,
    input  logic    fetch_i,
    input  logic    busy_i,
    input  logic    protect_i,
    input  decode_t dec_i,
    output logic    refuse_o,
    output logic    strobe_o
);
    logic is_flash;
    logic is_ram;
    logic busy_block;
    logic prot_block;

    assign is_flash   = dec_i.region == REG_FLASH;
    assign is_ram     = dec_i.region == REG_RAM;
    assign busy_block = busy_i && is_flash;
    assign prot_block = protect_i && !fetch_i && (is_flash || is_ram);
    assign refuse_o   = valid_i && (busy_block || prot_block);
    assign strobe_o   = valid_i && is_flash && !busy_block && !prot_block;
endmodule

// File: rtl/flash_bank_guard.sv
module flash_bank_guard
    import flsh_pkg::*;
#(
    parameter logic [23:0] RAM_BASE  = 24'h00FA00,
    parameter int          RAM_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        remap_sel_i,
    input  logic        req_valid_i,
    input  logic [23:0] req_addr_i,
    input  logic        req_fetch_i,
    input  logic        flash_busy_i,
    input  logic        protect_i,
    output logic        arr_en_o,
    output logic [14:0] arr_addr_o,
    input  logic [31:0] arr_rdata_i,
    output logic        rsp_valid_o,
    output logic        rsp_hit_o,
    output logic        rsp_ram_o,
    output logic        rsp_ext_o,
    output logic [1:0]  rsp_bank_o,
    output logic [14:0] rsp_word_o,
    output logic        rsp_err_o,
    output logic [31:0] rsp_data_o
);
    logic    high_eff;
    logic    high_q;
    logic    init_done;
    decode_t dec;
    logic    refuse;
    logic    strobe;
    resp_t   rsp_q;
    resp_t   rsp_d;

    flsh_remap_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (remap_sel_i),
        .high_o   (high_eff),
        .high_q_o (high_q),
        .done_o   (init_done)
    );

    flsh_bank_decode #(
        .RAM_BASE  (RAM_BASE),
        .RAM_BYTES (RAM_BYTES)
    ) u_dec (
        .addr_i (req_addr_i),
        .high_i (high_eff),
        .dec_o  (dec)
    );

    flsh_access_policy u_pol (
        .valid_i   (req_valid_i),
        .fetch_i   (req_fetch_i),
        .busy_i    (flash_busy_i),
        .protect_i (protect_i),
        .dec_i     (dec),
        .refuse_o  (refuse),
        .strobe_o  (strobe)
    );

    always_comb begin
        rsp_d           = '0;
        rsp_d.valid     = req_valid_i;
        if (req_valid_i) begin
            rsp_d.hit       = dec.region == REG_FLASH;
            rsp_d.ram       = dec.region == REG_RAM;
            rsp_d.ext       = dec.region == REG_EXT;
            rsp_d.bank      = dec.bank;
            rsp_d.word      = dec.word;
            rsp_d.err       = refuse;
            rsp_d.pass_data = strobe;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign arr_en_o    = strobe;
    assign arr_addr_o  = dec.word;
    assign rsp_valid_o = rsp_q.valid;
    assign rsp_hit_o   = rsp_q.hit;
    assign rsp_ram_o   = rsp_q.ram;
    assign rsp_ext_o   = rsp_q.ext;
    assign rsp_bank_o  = rsp_q.bank;
    assign rsp_word_o  = rsp_q.word;
    assign rsp_err_o   = rsp_q.err;
    assign rsp_data_o  = rsp_q.pass_data ? arr_rdata_i : '0;
endmodule

// File: rtl/flsh_guard_chk.sv
module flsh_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid_i,
    input logic        req_fetch_i,
    input logic        flash_busy_i,
    input logic        protect_i,
    input logic        arr_en_o,
    input logic        rsp_valid_o,
    input logic        rsp_hit_o,
    input logic        rsp_ram_o,
    input logic        rsp_ext_o,
    input logic        rsp_err_o,
    input logic [31:0] rsp_data_o,
    input logic        high_q,
    input logic        init_done
);
    p_one_region_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> $countones({rsp_hit_o, rsp_ram_o, rsp_ext_o}) == 1);

    p_placement_held_r5: assert property (@(posedge clk) disable iff (rst)
        (init_done && $past(init_done)) |-> $stable(high_q));

    p_busy_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        arr_en_o |-> !flash_busy_i);

    p_refused_zero_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_err_o |-> (rsp_data_o == 32'd0));

    p_prot_read_refused_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && protect_i && !req_fetch_i) |-> !arr_en_o);

    p_resp_latency_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!rsp_valid_o && !rsp_err_o));
endmodule

bind flash_bank_guard flsh_guard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid_i  (req_valid_i),
    .req_fetch_i  (req_fetch_i),
    .flash_busy_i (flash_busy_i),
    .protect_i    (protect_i),
    .arr_en_o     (arr_en_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_hit_o    (rsp_hit_o),
    .rsp_ram_o    (rsp_ram_o),
    .rsp_ext_o    (rsp_ext_o),
    .rsp_err_o    (rsp_err_o),
    .rsp_data_o   (rsp_data_o),
    .high_q       (high_q),
    .init_done    (init_done)
);

// File: tb/sim_flash_bank_guard.sv
`timescale 1ns/1ps
module sim_flash_bank_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        remap_sel_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [23:0] req_addr_i = '0;
    logic        req_fetch_i = 1'b0;
    logic        flash_busy_i = 1'b0;
    logic        protect_i = 1'b0;
    logic        arr_en_o;
    logic [14:0] arr_addr_o;
    logic [31:0] arr_rdata_i = '0;
    logic        rsp_valid_o, rsp_hit_o, rsp_ram_o, rsp_ext_o, rsp_err_o;
    logic [1:0]  rsp_bank_o;
    logic [14:0] rsp_word_o;
    logic [31:0] rsp_data_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    flash_bank_guard u0 (.*);

    // array model: one-cycle read latency, data tagged with the word index
    always_ff @(posedge clk) if (arr_en_o) arr_rdata_i <= {8'hC3, 9'h0, arr_addr_o};

    typedef struct packed {
        logic        seg;
        logic        fetch;
        logic        busy;
        logic        prot;
        logic [23:0] addr;
        logic        hit;
        logic [1:0]  bank;
        logic [14:0] word;
        logic        ram;
        logic        ext;
        logic        err;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        // R1: low placement, movable banks
        '{1'b0,1'b0,1'b0,1'b0,24'h000000,1'b1,2'd0,15'h0000,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,24'h001FFF,1'b1,2'd0,15'h07FF,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b0,1'b0,24'h002000,1'b1,2'd1,15'h0800,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,24'h007FFF,1'b1,2'd1,15'h1FFF,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,24'h008000,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,24'h010000,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,24'h017FFF,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0},
        // R3: fixed banks under low placement
        '{1'b0,1'b0,1'b0,1'b0,24'h018000,1'b1,2'd2,15'h2000,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,24'h023FFF,1'b1,2'd2,15'h4FFF,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b0,1'b0,24'h024000,1'b1,2'd3,15'h5000,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,24'h02FFFF,1'b1,2'd3,15'h7FFF,1'b0,1'b0,1'b0},
        // R4: outside, RAM window edges
        '{1'b0,1'b0,1'b0,1'b0,24'h030000,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,24'h00FA00,1'b0,2'd0,15'h0000,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,24'h00FDFF,1'b0,2'd0,15'h0000,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,24'h00FE00,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0},
        // R6: busy refuses flash fetch and read; R11: not RAM or external
        '{1'b0,1'b1,1'b1,1'b0,24'h002000,1'b1,2'd1,15'h0800,1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b1,1'b0,24'h024000,1'b1,2'd3,15'h5000,1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b1,1'b0,24'h00FA00,1'b0,2'd0,15'h0000,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,1'b0,24'h040000,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0},
        // R7: protection; R11: fetches and external reads unaffected
        '{1'b0,1'b0,1'b0,1'b1,24'h000004,1'b1,2'd0,15'h0001,1'b0,1'b0,1'b1},
        '{1'b0,1'b1,1'b0,1'b1,24'h000004,1'b1,2'd0,15'h0001,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,24'h00FA10,1'b0,2'd0,15'h0000,1'b1,1'b0,1'b1},
        '{1'b0,1'b1,1'b0,1'b1,24'h00FA10,1'b0,2'd0,15'h0000,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,24'h100000,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0},
        // R2: high placement
        '{1'b1,1'b0,1'b0,1'b0,24'h000000,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,24'h007FFF,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,24'h010000,1'b1,2'd0,15'h0000,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,24'h011FFF,1'b1,2'd0,15'h07FF,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b0,1'b0,24'h012000,1'b1,2'd1,15'h0800,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,24'h017FFF,1'b1,2'd1,15'h1FFF,1'b0,1'b0,1'b0},
        // R3: fixed banks under high placement
        '{1'b1,1'b0,1'b0,1'b0,24'h018000,1'b1,2'd2,15'h2000,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,24'h02FFFF,1'b1,2'd3,15'h7FFF,1'b0,1'b0,1'b0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst = 1'b1;
        req_valid_i = 1'b0;
        remap_sel_i = sel;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R10 valid in reset", 64'(rsp_valid_o), 64'd0);
        check("R10 err in reset", 64'(rsp_err_o), 64'd0);
        check("R10 data in reset", 64'(rsp_data_o), 64'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        logic        acc;
        logic [31:0] exp_data;
        acc      = v.hit && !v.err;
        exp_data = acc ? {8'hC3, 9'h0, v.word} : 32'd0;
        req_valid_i  = 1'b1;
        req_addr_i   = v.addr;
        req_fetch_i  = v.fetch;
        flash_busy_i = v.busy;
        protect_i    = v.prot;
        #1;
        check({tag, " R9 strobe"}, 64'(arr_en_o), 64'(acc));
        if (acc) check({tag, " R9 array index"}, 64'(arr_addr_o), 64'(v.word));
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8 valid"}, 64'(rsp_valid_o), 64'd1);
        check({tag, " R4 region"}, 64'({rsp_hit_o, rsp_ram_o, rsp_ext_o}), 64'({v.hit, v.ram, v.ext}));
        check({tag, " bank"}, 64'(rsp_bank_o), 64'(v.bank));
        check({tag, " word"}, 64'(rsp_word_o), 64'(v.word));
        check({tag, " R6/R7 err"}, 64'(rsp_err_o), 64'(v.err));
        check({tag, " R9 data"}, 64'(rsp_data_o), 64'(exp_data));
        req_valid_i  = 1'b0;
        flash_busy_i = 1'b0;
        protect_i    = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic cur_seg;
        vec_t v;
        cur_seg = 1'b0;
        do_reset(1'b0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].seg != cur_seg) begin
                cur_seg = VEC[i].seg;
                do_reset(cur_seg);
            end
            run_vec(VEC[i], $sformatf("vec%0d", i));
        end

        // R8: an idle cycle yields no response and no error
        @(posedge clk);
        @(negedge clk);
        check("R8 idle valid", 64'(rsp_valid_o), 64'd0);
        check("R8 idle err", 64'(rsp_err_o), 64'd0);

        // R5: selection flipped after the latch edge is ignored
        do_reset(1'b1);
        remap_sel_i = 1'b0;
        v = '{1'b1,1'b0,1'b0,1'b0,24'h010004,1'b1,2'd0,15'h0001,1'b0,1'b0,1'b0};
        run_vec(v, "R5 high kept");
        v = '{1'b1,1'b0,1'b0,1'b0,24'h000004,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0};
        run_vec(v, "R5 low stays external");

        // R5: reverse direction, low latched then selection raised
        do_reset(1'b0);
        remap_sel_i = 1'b1;
        v = '{1'b0,1'b0,1'b0,1'b0,24'h002004,1'b1,2'd1,15'h0801,1'b0,1'b0,1'b0};
        run_vec(v, "R5 low kept");
        v = '{1'b0,1'b0,1'b0,1'b0,24'h012000,1'b0,2'd0,15'h0000,1'b0,1'b1,1'b0};
        run_vec(v, "R5 high stays external");

        // R7: protected fetch from the last bank returns full word
        v = '{1'b0,1'b1,1'b0,1'b1,24'h02FFFC,1'b1,2'd3,15'h7FFF,1'b0,1'b0,1'b0};
        run_vec(v, "R7 fetch top");

        // R6: busy and protection together on a fetch still refuse
        v = '{1'b0,1'b1,1'b1,1'b1,24'h018000,1'b1,2'd2,15'h2000,1'b0,1'b0,1'b1};
        run_vec(v, "R6 busy fetch prot");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule